// File: doc/BRIEF.md
# Threshold-Driven Flow-Control Character Inserter

This block sits between a receive FIFO of 64 entries and a UART transmitter. It watches the receive fill count. When the count climbs above a programmable halt level, it asks the transmitter to send a pause character, so that the far end stops sending. When the count later drains down to a programmable resume level, it asks for a restart character. The two levels come from one 8-bit threshold register, with four bits for each level. Together they form a hysteresis band, so no character is repeated while the count stays between them.

A flow character is offered on `flow_req_o` together with `flow_byte_o`. The transmitter gives it priority over its own FIFO data at the next character boundary. It takes the byte by raising `tx_ready_i` for one cycle while the request is high. Once raised, a request is never withdrawn or altered until it is taken, so a character already in flight is never cut short. A 2-bit mode field chooses between the first set of characters, the second set, both in sequence, or none. The byte is masked to the current word length so that it is framed like any data byte.

The sequencer has six states. `ST_FLOW` means the far end is allowed to send. `ST_OFF_A` and `ST_OFF_B` offer the first and second pause characters. `ST_HELD` means a pause has been sent. `ST_ON_A` and `ST_ON_B` offer the first and second restart characters. The transitions are as follows:
- FLOW to OFF_A when the count is above the halt level and the mode is not 00.
- OFF_A to OFF_B on acceptance in paired mode.
- OFF_A to HELD on acceptance in single mode.
- OFF_B to HELD on acceptance.
- HELD to ON_A when the count is at or below the resume level and the mode is not 00.
- ON_A to ON_B on acceptance in paired mode.
- ON_A to FLOW on acceptance in single mode.
- ON_B to FLOW on acceptance.

Top module: `flowchar_inserter`

## Requirements
- R1: The halt level is `thresh_i[3:0]`×4 and the resume level is `thresh_i[7:4]`×4, both in FIFO entries (0 to 60).
- R2: In ST_FLOW with mode not 00, a count strictly greater than the halt level raises `flow_req_o` with the pause character one clock later. A count equal to the halt level does not.
- R3: In ST_HELD with mode not 00, a count less than or equal to the resume level raises `flow_req_o` with the restart character one clock later. A count one above the resume level does not.
- R4: After a pause character is accepted, no further request appears while the count stays above the resume level. After a restart character is accepted, no further request appears while the count stays at or below the halt level. A restart character is only ever offered after a pause character has been accepted.
- R5: Mode 10 sends the first pair of characters (`xoff1_i` and `xon1_i`). Mode 01 sends the second pair (`xoff2_i` and `xon2_i`).
- R6: Mode 11 sends `xoff1_i` and then `xoff2_i`, or `xon1_i` and then `xon2_i`. The second character is offered in the cycle right after the first is accepted.
- R7: With mode 00, no new request is raised from ST_FLOW or ST_HELD, whatever the count.
- R8: A character is accepted at a clock edge where both `flow_req_o` and `tx_ready_i` are high. Until then, `flow_req_o` stays high and `flow_byte_o` does not change.
- R9: `word_len_i` 00, 01, 10 and 11 select 5, 6, 7 and 8 bits. Bits of `flow_byte_o` at or above the word length are zero, and the lower bits equal the programmed character.
- R10: While `rst_n` is low and just after it is released, `flow_req_o` is 0 and the sequencer is in ST_FLOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_count_i | input | 7 | Receive FIFO fill count, 0 to 64 |
| thresh_i | input | 8 | [3:0] halt code, [7:4] resume code |
| mode_i | input | 2 | 00 none, 10 set 1, 01 set 2, 11 both in sequence |
| xon1_i | input | 8 | First restart character |
| xon2_i | input | 8 | Second restart character |
| xoff1_i | input | 8 | First pause character |
| xoff2_i | input | 8 | Second pause character |
| word_len_i | input | 2 | Word length code, 5 + value bits |
| tx_ready_i | input | 1 | Transmitter at a character boundary, takes the offered byte |
| flow_req_o | output | 1 | A flow character is offered |
| flow_byte_o | output | 8 | Offered character, masked to the word length |

## Verification
A table of single-threshold crossings is applied from reset. Each entry uses counts just above and exactly at the halt level, including the extreme codes 0 and 15, so that an off-by-one comparison or a wrong scale factor shows up. The table also covers each mode and each word length, so that swapped character sets and wrong masks are told apart. Directed sequences then walk through the full pause-hold-resume cycle. These sequences hold `tx_ready_i` low to prove the offer is stable, probe the resume boundary from one entry above, and check that a count sitting inside the band gives no repeat. Finally, they run the paired mode and switch the mode to 00 while held.

// File: rtl/flowchar_pkg.sv
package flowchar_pkg;

    localparam int DATA_W   = 8;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_FLOW  = 3'd0,
        ST_OFF_A = 3'd1,
        ST_OFF_B = 3'd2,
        ST_HELD  = 3'd3,
        ST_ON_A  = 3'd4,
        ST_ON_B  = 3'd5
    } fc_state_t;

    localparam logic [1:0] MODE_NONE = 2'b00;
    localparam logic [1:0] MODE_ALT  = 2'b01;
    localparam logic [1:0] MODE_PRI  = 2'b10;
    localparam logic [1:0] MODE_BOTH = 2'b11;

endpackage

// File: rtl/fc_level_monitor.sv
module fc_level_monitor #(
    parameter int CNT_W     = 7,
    parameter int CODE_W    = 4,
    parameter int LVL_SHIFT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    count_i,
    input  logic [2*CODE_W-1:0] thresh_i,
    output logic                above_halt_o,
    output logic                at_resume_o
);
    localparam int LVL_W   = CODE_W + LVL_SHIFT;
    localparam int LVL_MAX = ((1 << CODE_W) - 1) << LVL_SHIFT;

    logic [LVL_W-1:0] halt_lvl;
    logic [LVL_W-1:0] resume_lvl;
    logic [CNT_W-1:0] halt_ext;
    logic [CNT_W-1:0] resume_ext;

    always_comb begin
        halt_lvl   = {thresh_i[CODE_W-1:0], {LVL_SHIFT{1'b0}}};
        resume_lvl = {thresh_i[2*CODE_W-1:CODE_W], {LVL_SHIFT{1'b0}}};
        halt_ext   = CNT_W'(halt_lvl);
        resume_ext = CNT_W'(resume_lvl);
        above_halt_o = (count_i > halt_ext);
        at_resume_o  = (count_i <= resume_ext);
    end

    // R1
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(halt_ext) <= LVL_MAX) && (int'(resume_ext) <= LVL_MAX));

    // R1
    level_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_ext < halt_ext) |-> !(above_halt_o && at_resume_o));

endmodule

// File: rtl/fc_char_picker.sv
module fc_char_picker
    import flowchar_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int MB = MIN_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pick_on_i,
    input  logic         pick_alt_i,
    input  logic [W-1:0] xon1_i,
    input  logic [W-1:0] xon2_i,
    input  logic [W-1:0] xoff1_i,
    input  logic [W-1:0] xoff2_i,
    input  logic [1:0]   word_len_i,
    output logic [W-1:0] byte_o
);
    logic [W-1:0] raw;
    logic [W-1:0] mask;
    int unsigned  nbits;

    always_comb begin
        nbits = MB + int'(word_len_i);
        unique case ({pick_on_i, pick_alt_i})
            2'b00:   raw = xoff1_i;
            2'b01:   raw = xoff2_i;
            2'b10:   raw = xon1_i;
            default: raw = xon2_i;
        endcase
    end

    for (genvar b = 0; b < W; b++) begin : g_mask
        assign mask[b] = (b < nbits);
    end

    assign byte_o = raw & mask;

    // R9
    trunc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_o[MB-1:0] == raw[MB-1:0]));

    // R9
    trunc_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_len_i == 2'b00) |-> (byte_o[W-1:MB] == '0));

endmodule

// File: rtl/fc_sequencer.sv
module fc_sequencer
    import flowchar_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic         above_halt_i,
    input  logic         at_resume_i,
    input  logic         tx_ready_i,
    input  logic [W-1:0] picked_i,
    output logic         pick_on_o,
    output logic         pick_alt_o,
    output logic         flow_req_o,
    output logic [W-1:0] flow_byte_o
);
    fc_state_t    state_q, state_d;
    logic         pair_q, pair_d;
    logic [W-1:0] byte_q;
    logic         accept;
    logic         enabled;
    logic         load;

    assign accept  = flow_req_o && tx_ready_i;
    assign enabled = (mode_i != MODE_NONE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
            pair_q  <= 1'b0;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            pair_q  <= pair_d;
            if (load) byte_q <= picked_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        pair_d  = pair_q;
        unique case (state_q)
            ST_FLOW: if (enabled && above_halt_i) begin
                state_d = ST_OFF_A;
                pair_d  = (mode_i == MODE_BOTH);
            end
            ST_OFF_A: if (accept) state_d = pair_q ? ST_OFF_B : ST_HELD;
            ST_OFF_B: if (accept) state_d = ST_HELD;
            ST_HELD: if (enabled && at_resume_i) begin
                state_d = ST_ON_A;
                pair_d  = (mode_i == MODE_BOTH);
            end
            ST_ON_A: if (accept) state_d = pair_q ? ST_ON_B : ST_FLOW;
            ST_ON_B: if (accept) state_d = ST_FLOW;
            default: state_d = ST_FLOW;
        endcase
    end

    // outputs and character selection
    always_comb begin
        pick_on_o  = (state_d == ST_ON_A) || (state_d == ST_ON_B);
        pick_alt_o = (state_d == ST_OFF_B) || (state_d == ST_ON_B) ||
                     (mode_i == MODE_ALT);
        load       = (state_d != state_q) &&
                     (state_d != ST_FLOW) && (state_d != ST_HELD);
        unique case (state_q)
            ST_OFF_A, ST_OFF_B, ST_ON_A, ST_ON_B: flow_req_o = 1'b1;
            default:                              flow_req_o = 1'b0;
        endcase
        flow_byte_o = byte_q;
    end

    // R8
    hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_req_o && !tx_ready_i) |=> (flow_req_o && $stable(flow_byte_o)));

    // R2
    halt_reaction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLOW && mode_i != MODE_NONE && above_halt_i)
        |=> (flow_req_o && state_q == ST_OFF_A));

    // R7
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FLOW || state_q == ST_HELD) && mode_i == MODE_NONE)
        |=> !flow_req_o);

    // R4
    on_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLOW) |=> (state_q == ST_FLOW || state_q == ST_OFF_A));

    // R4
    held_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD) |=> (state_q == ST_HELD || state_q == ST_ON_A));

    // R6
    pair_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF_A && pair_q && accept) |=> (state_q == ST_OFF_B && flow_req_o));

endmodule

// File: rtl/flowchar_inserter.sv
module flowchar_inserter
    import flowchar_pkg::*;
#(
    parameter int CNT_W     = 7,
    parameter int CODE_W    = 4,
    parameter int LVL_SHIFT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    rx_count_i,
    input  logic [2*CODE_W-1:0] thresh_i,
    input  logic [1:0]          mode_i,
    input  logic [DATA_W-1:0]   xon1_i,
    input  logic [DATA_W-1:0]   xon2_i,
    input  logic [DATA_W-1:0]   xoff1_i,
    input  logic [DATA_W-1:0]   xoff2_i,
    input  logic [1:0]          word_len_i,
    input  logic                tx_ready_i,
    output logic                flow_req_o,
    output logic [DATA_W-1:0]   flow_byte_o
);
    logic              above_halt;
    logic              at_resume;
    logic              pick_on;
    logic              pick_alt;
    logic [DATA_W-1:0] picked;

    fc_level_monitor #(
        .CNT_W(CNT_W), .CODE_W(CODE_W), .LVL_SHIFT(LVL_SHIFT)
    ) u_level (
        .clk(clk), .rst_n(rst_n),
        .count_i(rx_count_i), .thresh_i(thresh_i),
        .above_halt_o(above_halt), .at_resume_o(at_resume)
    );

    fc_char_picker #(.W(DATA_W), .MB(MIN_BITS)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .pick_on_i(pick_on), .pick_alt_i(pick_alt),
        .xon1_i(xon1_i), .xon2_i(xon2_i),
        .xoff1_i(xoff1_i), .xoff2_i(xoff2_i),
        .word_len_i(word_len_i), .byte_o(picked)
    );

    fc_sequencer #(.W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .mode_i(mode_i), .above_halt_i(above_halt), .at_resume_i(at_resume),
        .tx_ready_i(tx_ready_i), .picked_i(picked),
        .pick_on_o(pick_on), .pick_alt_o(pick_alt),
        .flow_req_o(flow_req_o), .flow_byte_o(flow_byte_o)
    );

endmodule

// File: tb/tb_flowchar_inserter.sv
module tb_flowchar_inserter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] rx_count;
    logic [7:0] thresh;
    logic [1:0] mode;
    logic [1:0] wlen;
    logic       tx_ready;
    logic       req;
    logic [7:0] fbyte;

    localparam logic [7:0] XON1 = 8'h11, XON2 = 8'hA1, XOFF1 = 8'hF6, XOFF2 = 8'hE7;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flowchar_inserter dut (
        .clk(clk), .rst_n(rst_n), .rx_count_i(rx_count), .thresh_i(thresh),
        .mode_i(mode), .xon1_i(XON1), .xon2_i(XON2), .xoff1_i(XOFF1),
        .xoff2_i(XOFF2), .word_len_i(wlen), .tx_ready_i(tx_ready),
        .flow_req_o(req), .flow_byte_o(fbyte)
    );

    typedef struct packed {
        logic [7:0] th;
        logic [1:0] md;
        logic [1:0] wl;
        logic [6:0] cnt;
        logic       ereq;
        logic [7:0] ebyte;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h25, 2'b10, 2'b11, 7'd21, 1'b1, 8'hF6},
        '{8'h25, 2'b10, 2'b11, 7'd20, 1'b0, 8'h00},
        '{8'h25, 2'b01, 2'b11, 7'd21, 1'b1, 8'hE7},
        '{8'h25, 2'b00, 2'b11, 7'd64, 1'b0, 8'h00},
        '{8'h25, 2'b10, 2'b00, 7'd21, 1'b1, 8'h16},
        '{8'h25, 2'b10, 2'b01, 7'd21, 1'b1, 8'h36},
        '{8'h25, 2'b10, 2'b10, 7'd21, 1'b1, 8'h76},
        '{8'h25, 2'b01, 2'b00, 7'd64, 1'b1, 8'h07},
        '{8'h00, 2'b10, 2'b11, 7'd1,  1'b1, 8'hF6},
        '{8'h00, 2'b10, 2'b11, 7'd0,  1'b0, 8'h00},
        '{8'h0F, 2'b11, 2'b11, 7'd61, 1'b1, 8'hF6},
        '{8'h0F, 2'b10, 2'b11, 7'd60, 1'b0, 8'h00}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tx_ready = 1'b0;
        rx_count = 7'd0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic accept();
        tx_ready = 1'b1;
        tick();
        tx_ready = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        thresh = 8'h25; mode = 2'b10; wlen = 2'b11;
        rst_n = 1'b0; tx_ready = 1'b0; rx_count = 7'd64;
        @(negedge clk);
        tick();
        chk("R10 req during reset", int'(req), 0);
        rst_n = 1'b1;
        rx_count = 7'd0;
        chk("R10 req after release", int'(req), 0);

        // table: R1 R2 R5 R7 R9 from reset
        for (int i = 0; i < NV; i++) begin
            do_reset();
            thresh = VECS[i].th; mode = VECS[i].md; wlen = VECS[i].wl;
            rx_count = VECS[i].cnt;
            tick();
            chk($sformatf("R2 vec%0d req", i), int'(req), int'(VECS[i].ereq));
            if (VECS[i].ereq)
                chk($sformatf("R9 vec%0d byte", i), int'(fbyte), int'(VECS[i].ebyte));
        end

        // R8 hold, R4 no repeat, R3 resume boundary
        do_reset();
        thresh = 8'h25; mode = 2'b10; wlen = 2'b11;
        rx_count = 7'd30;
        tick();
        tick(); tick(); tick();
        chk("R8 req held", int'(req), 1);
        chk("R8 byte held", int'(fbyte), int'(XOFF1));
        accept();
        chk("R8 req drops after accept", int'(req), 0);
        tick(); tick();
        chk("R4 no repeat above halt", int'(req), 0);
        rx_count = 7'd24; tick(); tick();
        chk("R4 no xon inside band", int'(req), 0);
        rx_count = 7'd9; tick(); tick();
        chk("R3 no xon one above resume", int'(req), 0);
        rx_count = 7'd8; tick();
        chk("R3 xon at resume", int'(req), 1);
        chk("R5 xon1 byte", int'(fbyte), int'(XON1));
        accept();
        chk("R4 flowing after xon", int'(req), 0);
        tick(); tick();
        chk("R4 no repeat xon", int'(req), 0);
        rx_count = 7'd20; tick();
        chk("R4 no xoff at halt level", int'(req), 0);

        // R6 pair
        do_reset();
        mode = 2'b11; rx_count = 7'd21;
        tick();
        chk("R6 first xoff", int'(fbyte), int'(XOFF1));
        accept();
        chk("R6 second req", int'(req), 1);
        chk("R6 second xoff", int'(fbyte), int'(XOFF2));
        accept();
        chk("R6 pair done", int'(req), 0);
        rx_count = 7'd0; tick();
        chk("R6 first xon", int'(fbyte), int'(XON1));
        accept();
        chk("R6 second xon", int'(fbyte), int'(XON2));
        accept();
        chk("R6 xon pair done", int'(req), 0);

        // R5 set 2 restart, then R7 mode 00 while held
        do_reset();
        mode = 2'b01; rx_count = 7'd40;
        tick(); accept();
        rx_count = 7'd2; tick();
        chk("R5 xon2 byte", int'(fbyte), int'(XON2));
        accept();
        rx_count = 7'd40; tick(); accept();
        mode = 2'b00; rx_count = 7'd0;
        tick(); tick();
        chk("R7 mode 00 held no xon", int'(req), 0);
        mode = 2'b10; tick();
        chk("R7 resumes when enabled", int'(req), 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule